// File: doc/BRIEF.md
# Three-Phase Deadtime Interlock

This block conditions the gate commands of a three-phase half-bridge inverter. Each phase has two request inputs, one for the upper switch and one for the lower switch. Each phase also has a matching pair of enable outputs. A high request asks for the matching switch to conduct. The block makes sure the two switches of one phase never conduct together. It also keeps a switch from turning on until a fixed deadtime, measured in cycles of the timing clock `clk`, has elapsed since the phase last had a different or empty command.

Requests arrive from another clock domain. Each one passes through a two-flop synchronizer before the per-phase logic sees it. Turning a switch off is immediate once the synchronized request drops. Only turn-on waits out the deadtime. An active-low reset clears everything at once. After reset is released, every switch must again wait the full deadtime.

All pins are plain level signals with no handshake. Phase index 0, 1, 2 maps to bit 0, 1, 2 of every vector port.

Top module: `bridge_interlock`

## Requirements
- R1: With only the upper (or only the lower) request of a phase high, that phase's matching enable rises exactly 10 `clk` periods after the first rising edge that samples the request high (2 synchronizer stages plus the deadtime of 8 periods). It then stays high while the request holds.
- R2: For every phase, `hi_en[i]` and `lo_en[i]` are never high at the same time.
- R3: When both requests of a phase are high, both enables of that phase are low by the third rising edge after the first edge that samples the pair. They stay low until one request drops. The side that remains requested then waits the full 10-period latency of R1.
- R4: When a request drops, its enable falls on the third rising edge after the first edge that samples it low. No deadtime applies to turn-off.
- R5: On a direct changeover from one side to the other, the incoming enable rises only after both enables of that phase have been low for 8 consecutive periods.
- R6: A request that drops before its deadtime completes abandons the turn-on, and re-asserting it restarts the full count. A request held for 8 periods never produces an enable. A request held for 9 periods produces exactly one period of enable.
- R7: While `rst_n` is low, all six enables are low, asynchronously and without waiting for a clock edge. Synchronizer and counter state are cleared.
- R8: After `rst_n` rises, requests that are already held turn on only after the full latency of R1, counted from the first edge after release.
- R9: The phases are independent. Activity on one phase does not alter the enables or timing of another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timing clock; the deadtime is counted in its periods |
| rst_n | input | 1 | Active-low reset, asynchronous assert, stops all switching |
| hi_req | input | 3 | Upper-switch requests, one bit per phase, high = on |
| lo_req | input | 3 | Lower-switch requests, one bit per phase, high = on |
| hi_en | output | 3 | Upper-switch enables, one bit per phase |
| lo_en | output | 3 | Lower-switch enables, one bit per phase |

## Verification
The bench targets the exact turn-on edge after a single request, after reset release and after a direct side changeover. A design with an off-by-one counter shows up one period early or late there, and one that skips the deadtime on changeover closes both switches back to back. It asserts both requests of a phase together, both while the phase is idle and while it is already conducting. A design lacking the interlock would leave a switch on or turn one on. Request pulses of 8 and 9 periods probe the boundary where a turn-on is abandoned. A pulse with a short gap checks that a design which failed to restart the count would turn on early. Asynchronous reset is applied while a switch conducts, and the outputs are checked before the next clock edge.

// File: rtl/bridge_pkg.sv
`timescale 1ns/1ps
package bridge_pkg;

  typedef enum logic [1:0] {
    SIDE_NONE = 2'b00,
    SIDE_HI   = 2'b01,
    SIDE_LO   = 2'b10
  } side_e;

  // A phase asks for a side only when exactly one request is high (R3).
  function automatic side_e pick_side(input logic up, input logic dn);
    if (up && !dn)      return SIDE_HI;
    else if (dn && !up) return SIDE_LO;
    else                return SIDE_NONE;
  endfunction

endpackage

// File: rtl/req_sync.sv
`timescale 1ns/1ps
module req_sync #(
  parameter int WIDTH  = 6,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) stg_q[k] <= '0;
    end else begin
      stg_q[0] <= d;
      for (int k = 1; k < STAGES; k++) stg_q[k] <= stg_q[k-1];
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/phase_gate.sv
`timescale 1ns/1ps
module phase_gate
  import bridge_pkg::*;
#(
  parameter int DEAD_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hi_s,
  input  logic lo_s,
  output logic hi_en,
  output logic lo_en
);

  localparam int CNT_W = $clog2(DEAD_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_DONE = CNT_W'(DEAD_CYCLES);

  side_e            want;
  side_e            tgt_q;
  logic [CNT_W-1:0] cnt_q;
  logic             on_q;

  assign want = pick_side(hi_s, lo_s);

  // Any change of the requested side drops the output at once and restarts
  // the count (R4, R6); a steady request counts up and then turns on (R1).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q <= SIDE_NONE;
      cnt_q <= '0;
      on_q  <= 1'b0;
    end else if (want != tgt_q) begin
      tgt_q <= want;
      cnt_q <= (want == SIDE_NONE) ? '0 : CNT_W'(1);
      on_q  <= 1'b0;
    end else if (want != SIDE_NONE) begin
      if (cnt_q == CNT_DONE) on_q  <= 1'b1;
      else                   cnt_q <= cnt_q + 1'b1;
    end
  end

  assign hi_en = on_q && (tgt_q == SIDE_HI);
  assign lo_en = on_q && (tgt_q == SIDE_LO);

endmodule

// File: rtl/bridge_interlock.sv
`timescale 1ns/1ps
module bridge_interlock #(
  parameter int PHASES      = 3,
  parameter int DEAD_CYCLES = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PHASES-1:0] hi_req,
  input  logic [PHASES-1:0] lo_req,
  output logic [PHASES-1:0] hi_en,
  output logic [PHASES-1:0] lo_en
);

  localparam int REQ_W = 2 * PHASES;

  logic [REQ_W-1:0] req_raw;
  logic [REQ_W-1:0] req_s;

  assign req_raw = {lo_req, hi_req};

  req_sync #(
    .WIDTH (REQ_W),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (req_raw),
    .q    (req_s)
  );

  for (genvar g = 0; g < PHASES; g++) begin : g_phase
    phase_gate #(
      .DEAD_CYCLES(DEAD_CYCLES)
    ) u_gate (
      .clk  (clk),
      .rst_n(rst_n),
      .hi_s (req_s[g]),
      .lo_s (req_s[PHASES+g]),
      .hi_en(hi_en[g]),
      .lo_en(lo_en[g])
    );
  end

endmodule

// File: rtl/bridge_interlock_chk.sv
`timescale 1ns/1ps
module bridge_interlock_chk #(
  parameter int PHASES      = 3,
  parameter int DEAD_CYCLES = 8,
  parameter int SYNC_STAGES = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [PHASES-1:0] hi_req,
  input logic [PHASES-1:0] lo_req,
  input logic [PHASES-1:0] hi_en,
  input logic [PHASES-1:0] lo_en
);

  localparam int CW  = $clog2(DEAD_CYCLES + 1);
  localparam int LAT = SYNC_STAGES + 1;

  // R7: reset holds every enable low.
  assert_reset_off_R7: assert property (@(posedge clk)
    !rst_n |-> (hi_en == '0 && lo_en == '0));

  for (genvar i = 0; i < PHASES; i++) begin : g_chk
    logic [CW-1:0] offc;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        offc <= '0;
      else if (hi_en[i] || lo_en[i])     offc <= '0;
      else if (offc != CW'(DEAD_CYCLES)) offc <= offc + 1'b1;
    end

    assert_no_overlap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(hi_en[i] && lo_en[i]));

    assert_conflict_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $past(hi_req[i] && lo_req[i], LAT) |-> (!hi_en[i] && !lo_en[i]));

    assert_hi_turnoff_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!hi_req[i], LAT) |-> !hi_en[i]);

    assert_lo_turnoff_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!lo_req[i], LAT) |-> !lo_en[i]);

    assert_deadtime_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(hi_en[i]) || $rose(lo_en[i])) |-> (offc == CW'(DEAD_CYCLES)));
  end

endmodule

bind bridge_interlock bridge_interlock_chk #(
  .PHASES     (PHASES),
  .DEAD_CYCLES(DEAD_CYCLES),
  .SYNC_STAGES(SYNC_STAGES)
) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .hi_req(hi_req),
  .lo_req(lo_req),
  .hi_en (hi_en),
  .lo_en (lo_en)
);

// File: tb/bridge_interlock_bench.sv
`timescale 1ns/1ps
module bridge_interlock_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] hi_req, lo_req;
  logic [2:0] hi_en, lo_en;

  always #4 clk = ~clk;

  bridge_interlock u_bridge_interlock (
    .clk   (clk),
    .rst_n (rst_n),
    .hi_req(hi_req),
    .lo_req(lo_req),
    .hi_en (hi_en),
    .lo_en (lo_en)
  );

  typedef struct {
    int         at;
    logic [2:0] hi;
    logic [2:0] lo;
    string      tag;
  } exp_t;

  exp_t sb[$];
  int   cyc    = 0;
  int   checks = 0;
  int   fails  = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string tag, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: hi/lo actual=%b_%b expected=%b_%b",
               tag, cyc, act[5:3], act[2:0], exp[5:3], exp[2:0]);
    end
  endtask

  task automatic expect_at(input int dly, input logic [2:0] h, input logic [2:0] l,
                           input string tag);
    sb.push_back('{at: cyc + dly, hi: h, lo: l, tag: tag});
  endtask

  task automatic drive(input logic [2:0] h, input logic [2:0] l);
    @(negedge clk);
    hi_req = h;
    lo_req = l;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: pops scoreboard items as their cycle arrives.
  always @(negedge clk) begin : mon
    exp_t e;
    while (sb.size() > 0 && sb[0].at <= cyc) begin
      e = sb.pop_front();
      check(e.tag, {hi_en, lo_en}, {e.hi, e.lo});
    end
  end

  initial begin : watchdog
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n  = 1'b0;
    hi_req = 3'b001;
    lo_req = 3'b000;
    idle(3);
    check("R7 reset state", {hi_en, lo_en}, 6'b0);

    // R8: release with phase A upper request already held
    rst_n = 1'b1;
    expect_at(10, 3'b000, 3'b000, "R8 before deadtime");
    expect_at(11, 3'b001, 3'b000, "R8 after deadtime");
    idle(14);

    // R1 / R9: phase B lower starts, phase A unaffected
    drive(3'b001, 3'b010);
    expect_at(10, 3'b001, 3'b000, "R9 phase A steady");
    expect_at(11, 3'b001, 3'b010, "R1 lower turn-on");
    idle(14);

    // R4: phase A upper drops
    drive(3'b000, 3'b010);
    expect_at(2, 3'b001, 3'b010, "R4 still on");
    expect_at(3, 3'b000, 3'b010, "R4 off");
    idle(6);

    // R3: conflict on idle phase C
    drive(3'b100, 3'b110);
    expect_at(3, 3'b000, 3'b010, "R3 conflict idle");
    expect_at(15, 3'b000, 3'b010, "R3 conflict held");
    idle(16);

    // R3: lower request of C drops, upper waits full deadtime
    drive(3'b100, 3'b010);
    expect_at(10, 3'b000, 3'b010, "R3 wait after conflict");
    expect_at(11, 3'b100, 3'b010, "R3 on after conflict");
    idle(14);

    // R3: conflict while C conducts
    drive(3'b100, 3'b110);
    expect_at(2, 3'b100, 3'b010, "R3 before conflict seen");
    expect_at(3, 3'b000, 3'b010, "R3 conflict kills on");
    idle(6);

    // R5: phase B lower -> upper changeover
    drive(3'b010, 3'b000);
    expect_at(2, 3'b000, 3'b010, "R5 lower still on");
    expect_at(3, 3'b000, 3'b000, "R5 gap start");
    expect_at(10, 3'b000, 3'b000, "R5 gap end");
    expect_at(11, 3'b010, 3'b000, "R5 upper on");
    idle(14);

    drive(3'b000, 3'b000);
    idle(6);

    // R6: 8-period pulse never turns on
    drive(3'b001, 3'b000);
    expect_at(11, 3'b000, 3'b000, "R6 8-pulse");
    expect_at(12, 3'b000, 3'b000, "R6 8-pulse");
    idle(7);
    drive(3'b000, 3'b000);
    idle(12);

    // R6: 9-period pulse gives one period of enable
    drive(3'b001, 3'b000);
    expect_at(10, 3'b000, 3'b000, "R6 9-pulse early");
    expect_at(11, 3'b001, 3'b000, "R6 9-pulse on");
    expect_at(12, 3'b000, 3'b000, "R6 9-pulse off");
    idle(8);
    drive(3'b000, 3'b000);
    idle(12);

    // R6: short gap restarts the count
    drive(3'b001, 3'b000);
    idle(4);
    drive(3'b000, 3'b000);
    idle(1);
    drive(3'b001, 3'b000);
    expect_at(10, 3'b000, 3'b000, "R6 restart early");
    expect_at(11, 3'b001, 3'b000, "R6 restart on");
    idle(14);

    // R7: asynchronous reset while conducting
    @(negedge clk);
    #1 rst_n = 1'b0;
    #1 check("R7 async off", {hi_en, lo_en}, 6'b0);
    @(negedge clk);
    rst_n = 1'b1;
    expect_at(10, 3'b000, 3'b000, "R8 re-release early");
    expect_at(11, 3'b001, 3'b000, "R8 re-release on");
    idle(14);

    while (sb.size() > 0) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule